// File: doc/BRIEF.md
# Memory Timing Derivation from Module Descriptor Bytes

This block turns a handful of bytes read from a memory module's serial-presence-detect descriptor into the settings a DRAM controller needs. After a start pulse it fetches seven descriptor bytes, one at a time, over a simple request/response byte port. The bytes are the supported CAS latencies, the cycle times at the highest, second and third latency, and the minimum row precharge, RAS-to-CAS and active-to-precharge times. It does not issue the next request until the response to the current one has come back. The bus transaction behind the port is handled elsewhere.

From the fetched bytes it selects a clock-period class and a matching clock-select code. It picks the lowest CAS latency whose cycle time still fits that period, and it rounds each row timing to a two-bit clock count by comparing it with multiples of the period. The results are packed into a timing byte, and the block pulses `done` for one cycle. Both output bytes keep their values until the next run completes.

Top module: `spd_timing_deriver`

## Requirements
- R1: While reset is held, and up to the first completed run after it, `req_valid`, `done`, `timing_byte` and `clk_sel` are all zero.
- R2: A run fetches descriptor addresses 18, 9, 23, 25, 27, 29, 30 in that order (CAS support, cycle time, second cycle time, third cycle time, tRP, tRCD, tRAS). Each request holds `req_valid` and `req_addr` steady until `req_ready`. After a request is accepted, `req_valid` stays low until `rsp_valid` returns its byte.
- R3: A cycle-time byte CT gives the period code P and the clock select. CT <= 0x50 gives P = 0x14 and `clk_sel` = 0x85. 0x50 < CT <= 0x60 gives P = 0x18 and 0x81. CT > 0x60 gives P = 0x1E and 0x80.
- R4: CAS field `timing_byte[5:4]` uses the codes 01 = 2, 10 = 2.5, 11 = 3. With support bit 4 set it starts at 3. It becomes 2.5 if bit 3 is set and the second cycle time is <= P. It becomes 2 if bit 2 is set and the third cycle time is <= P, and this last test takes precedence.
- R5: With support bit 4 clear, the CAS field is 2.5. It becomes 2 if bit 2 is set and the second cycle time is <= P.
- R6: tRP in `timing_byte[1:0]` and tRCD in `timing_byte[3:2]` are each 3, 2 or 1 when the descriptor value is >= 5P, 4P or 3P (highest match wins), else 0.
- R7: tRAS in `timing_byte[7:6]` is 3, 2 or 1 when the value is >= 9P, 8P or 7P, else 0. The products are formed at full width, so 9 × 0x1E = 270 is never met by a byte.
- R8: `done` is high for exactly one cycle. The new `timing_byte` and `clk_sel` appear in that same cycle and hold until the next run's `done`.
- R9: A start pulse during a run is ignored: the run fetches seven bytes and produces one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a derivation run (one-cycle pulse) |
| req_valid | output | 1 | Byte request pending |
| req_addr | output | 8 | Descriptor byte address requested |
| req_ready | input | 1 | Request accepted this cycle |
| rsp_valid | input | 1 | Response byte present |
| rsp_data | input | 8 | Response byte |
| timing_byte | output | 8 | Packed tRAS / CAS / tRCD / tRP fields |
| clk_sel | output | 8 | Clock-select code for the period class |
| done | output | 1 | One-cycle completion pulse |

## Verification
Directed runs place the cycle-time byte on each side of both class thresholds (0x50/0x51, 0x60/0x61), which separates the three period codes. They also set the row timing values exactly on a multiple of the period and one below it, so an off-by-one comparison or a wrong multiplier shows up. Separate CAS runs enable each support bit alone and in combination, with the reduced-latency cycle times just meeting or just missing the period; this shows whether the downgrade tests are ordered and gated correctly. A slow cycle time combined with tRAS = 0xFF shows whether the nine-times product is truncated to a byte. Random descriptor contents, random response delays and a start pulse sent in the middle of a run cover the fetch order, the one-request-at-a-time handshake and the rule that outputs hold between runs.

// File: rtl/spd_timing_pkg.sv
package spd_timing_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_CALC
  } seq_state_e;

  localparam int unsigned FETCH_N   = 7;
  localparam int unsigned SLOT_CAS  = 0;
  localparam int unsigned SLOT_CT   = 1;
  localparam int unsigned SLOT_CT2  = 2;
  localparam int unsigned SLOT_CT3  = 3;
  localparam int unsigned SLOT_RP   = 4;
  localparam int unsigned SLOT_RCD  = 5;
  localparam int unsigned SLOT_RAS  = 6;
endpackage

// File: rtl/spd_fetch_seq.sv
module spd_fetch_seq
  import spd_timing_pkg::*;
#(
  parameter int unsigned SLOTS = FETCH_N,
  parameter int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             req_valid,
  output logic [IDX_W-1:0] slot_idx,
  output logic             capture,
  output logic             calc
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_REQ;
        idx_d   = '0;
      end
      ST_REQ:  if (req_ready) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid) begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_CALC;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign req_valid = (state_q == ST_REQ);
  assign capture   = (state_q == ST_WAIT) && rsp_valid;
  assign calc      = (state_q == ST_CALC);
  assign slot_idx  = idx_q;
endmodule

// File: rtl/spd_byte_store.sv
module spd_byte_store #(
  parameter int unsigned SLOTS  = 7,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic [IDX_W-1:0]              slot_idx,
  input  logic [BYTE_W-1:0]             data_in,
  output logic [SLOTS-1:0][BYTE_W-1:0]  bytes
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic load_en;
    assign load_en = capture && (slot_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes[g] <= '0;
      end else if (load_en) begin
        bytes[g] <= data_in;
      end
    end
  end
endmodule

// File: rtl/spd_timing_calc.sv
module spd_timing_calc
  import spd_timing_pkg::*;
#(
  parameter int unsigned  SLOTS      = FETCH_N,
  parameter int unsigned  BYTE_W     = 8,
  parameter int unsigned  MULT_W     = 12,
  parameter logic [7:0]   CT_FAST    = 8'h50,
  parameter logic [7:0]   CT_MID     = 8'h60,
  parameter logic [7:0]   PER_FAST   = 8'h14,
  parameter logic [7:0]   PER_MID    = 8'h18,
  parameter logic [7:0]   PER_SLOW   = 8'h1E,
  parameter logic [7:0]   SEL_FAST   = 8'h85,
  parameter logic [7:0]   SEL_MID    = 8'h81,
  parameter logic [7:0]   SEL_SLOW   = 8'h80,
  parameter int unsigned  SHORT_BASE = 3,
  parameter int unsigned  LONG_BASE  = 7
) (
  input  logic [SLOTS-1:0][BYTE_W-1:0] bytes,
  output logic [7:0]                   timing_nxt,
  output logic [7:0]                   clksel_nxt
);
  localparam int unsigned ROWS = 3;

  logic [BYTE_W-1:0] period;
  logic [BYTE_W-1:0] sup, ct, ct2, ct3;
  logic [1:0]        cas_code;
  logic [MULT_W-1:0] per_w;
  logic [BYTE_W-1:0] row_val [ROWS];
  logic [1:0]        row_fld [ROWS];

  assign sup = bytes[SLOT_CAS];
  assign ct  = bytes[SLOT_CT];
  assign ct2 = bytes[SLOT_CT2];
  assign ct3 = bytes[SLOT_CT3];
  assign row_val[0] = bytes[SLOT_RP];
  assign row_val[1] = bytes[SLOT_RCD];
  assign row_val[2] = bytes[SLOT_RAS];

  always_comb begin
    if (ct <= CT_FAST) begin
      period     = PER_FAST;
      clksel_nxt = SEL_FAST;
    end else if (ct <= CT_MID) begin
      period     = PER_MID;
      clksel_nxt = SEL_MID;
    end else begin
      period     = PER_SLOW;
      clksel_nxt = SEL_SLOW;
    end
  end

  always_comb begin
    if (sup[4]) begin
      cas_code = 2'b11;
      if (sup[3] && (ct2 <= period)) cas_code = 2'b10;
      if (sup[2] && (ct3 <= period)) cas_code = 2'b01;
    end else begin
      cas_code = 2'b10;
      if (sup[2] && (ct2 <= period)) cas_code = 2'b01;
    end
  end

  assign per_w = MULT_W'(period);

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    localparam int unsigned LO = (g == ROWS - 1) ? LONG_BASE : SHORT_BASE;
    logic [MULT_W-1:0] val_w, lim1, lim2, lim3;
    assign val_w = MULT_W'(row_val[g]);
    assign lim1  = MULT_W'(LO) * per_w;
    assign lim2  = MULT_W'(LO + 1) * per_w;
    assign lim3  = MULT_W'(LO + 2) * per_w;
    assign row_fld[g] = (val_w >= lim3) ? 2'd3 :
                        (val_w >= lim2) ? 2'd2 :
                        (val_w >= lim1) ? 2'd1 : 2'd0;
  end

  assign timing_nxt = {row_fld[2], cas_code, row_fld[1], row_fld[0]};
endmodule

// File: rtl/spd_timing_deriver.sv
module spd_timing_deriver
  import spd_timing_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned MULT_W   = 12,
  parameter logic [7:0]  ADR_CAS  = 8'd18,
  parameter logic [7:0]  ADR_CT   = 8'd9,
  parameter logic [7:0]  ADR_CT2  = 8'd23,
  parameter logic [7:0]  ADR_CT3  = 8'd25,
  parameter logic [7:0]  ADR_RP   = 8'd27,
  parameter logic [7:0]  ADR_RCD  = 8'd29,
  parameter logic [7:0]  ADR_RAS  = 8'd30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic [7:0]        timing_byte,
  output logic [7:0]        clk_sel,
  output logic              done
);
  localparam int unsigned IDX_W = $clog2(FETCH_N);

  logic [1:0]                      rst_sync;
  logic                            rst_int_n;
  logic [IDX_W-1:0]                slot_idx;
  logic                            capture, calc;
  logic [FETCH_N-1:0][BYTE_W-1:0]  bytes;
  logic [ADDR_W-1:0]               addr_tab [FETCH_N];
  logic [7:0]                      timing_nxt, clksel_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign addr_tab[SLOT_CAS] = ADDR_W'(ADR_CAS);
  assign addr_tab[SLOT_CT]  = ADDR_W'(ADR_CT);
  assign addr_tab[SLOT_CT2] = ADDR_W'(ADR_CT2);
  assign addr_tab[SLOT_CT3] = ADDR_W'(ADR_CT3);
  assign addr_tab[SLOT_RP]  = ADDR_W'(ADR_RP);
  assign addr_tab[SLOT_RCD] = ADDR_W'(ADR_RCD);
  assign addr_tab[SLOT_RAS] = ADDR_W'(ADR_RAS);

  spd_fetch_seq #(.SLOTS(FETCH_N), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .slot_idx  (slot_idx),
    .capture   (capture),
    .calc      (calc)
  );

  assign req_addr = addr_tab[slot_idx];

  spd_byte_store #(.SLOTS(FETCH_N), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .capture  (capture),
    .slot_idx (slot_idx),
    .data_in  (rsp_data),
    .bytes    (bytes)
  );

  spd_timing_calc #(.SLOTS(FETCH_N), .BYTE_W(BYTE_W), .MULT_W(MULT_W)) u_calc (
    .bytes      (bytes),
    .timing_nxt (timing_nxt),
    .clksel_nxt (clksel_nxt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      timing_byte <= '0;
      clk_sel     <= '0;
      done        <= 1'b0;
    end else begin
      done <= calc;
      if (calc) begin
        timing_byte <= timing_nxt;
        clk_sel     <= clksel_nxt;
      end
    end
  end
endmodule

// File: rtl/spd_timing_checker.sv
module spd_timing_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [7:0]        timing_byte,
  input logic [7:0]        clk_sel,
  input logic              done
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pending <= 1'b0;
    else if (req_valid && req_ready) pending <= 1'b1;
    else if (rsp_valid)              pending <= 1'b0;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !req_valid);

  assert_clk_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_sel == 8'h85 || clk_sel == 8'h81 || clk_sel == 8'h80));

  assert_cas_coded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (timing_byte[5:4] != 2'b00));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timing_byte) |-> done);

  assert_hold_clksel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> done);
endmodule

bind spd_timing_deriver spd_timing_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .timing_byte (timing_byte),
  .clk_sel     (clk_sel),
  .done        (done)
);

// File: tb/sim_spd_timing_deriver.sv
`timescale 1ns/1ps
module sim_spd_timing_deriver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       req_ready = 1'b0;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic       req_valid;
  logic [7:0] req_addr;
  logic [7:0] timing_byte, clk_sel;
  logic       done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] spd [256];
  logic [7:0] addr_log [16];
  int         n_log = 0;
  bit         hs_bad = 1'b0;
  int         n_done = 0;
  logic [7:0] prev_timing = 8'h00;
  logic [7:0] prev_sel = 8'h00;

  always #4 clk = ~clk;

  spd_timing_deriver u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .timing_byte(timing_byte), .clk_sel(clk_sel), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mdl_period(input logic [7:0] ct);
    if (ct <= 8'd80) return 20;
    if (ct <= 8'd96) return 24;
    return 30;
  endfunction

  function automatic logic [7:0] mdl_sel(input logic [7:0] ct);
    case (mdl_period(ct))
      20:      return 8'h85;
      24:      return 8'h81;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [1:0] mdl_cas(input logic [7:0] sup, ct2, ct3, input int p);
    int tenths;
    if (sup[4]) begin
      tenths = 30;
      if (sup[3] && int'(ct2) <= p) tenths = 25;
      if (sup[2] && int'(ct3) <= p) tenths = 20;
    end else begin
      tenths = 25;
      if (sup[2] && int'(ct2) <= p) tenths = 20;
    end
    return (tenths == 30) ? 2'd3 : (tenths == 25) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [1:0] mdl_row(input logic [7:0] v, input int p, input int lo);
    for (int k = 2; k >= 0; k--) begin
      if (int'(v) >= (lo + k) * p) return 2'(k + 1);
    end
    return 2'd0;
  endfunction

  // responder on the byte port, with random accept and reply delays
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        repeat ($urandom % 3) @(negedge clk);
        req_ready = 1'b1;
        if (n_log < 16) addr_log[n_log] = req_addr;
        n_log++;
        @(negedge clk);
        req_ready = 1'b0;
        if (req_valid) hs_bad = 1'b1;
        repeat ($urandom % 3) begin
          @(negedge clk);
          if (req_valid) hs_bad = 1'b1;
        end
        rsp_valid = 1'b1;
        rsp_data  = spd[addr_log[(n_log - 1) % 16]];
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  always @(posedge clk) if (done) n_done++;

  task automatic run_case(input logic [7:0] sup, ct, ct2, ct3, rp, rcd, ras, input bit poke);
    int p;
    logic [7:0] order [7];
    logic [1:0] cas_exp;
    int d0;
    order = '{8'd18, 8'd9, 8'd23, 8'd25, 8'd27, 8'd29, 8'd30};
    spd[18] = sup; spd[9] = ct; spd[23] = ct2; spd[25] = ct3;
    spd[27] = rp; spd[29] = rcd; spd[30] = ras;
    n_log = 0; hs_bad = 1'b0; d0 = n_done;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8 timing held during run", {24'h0, timing_byte}, {24'h0, prev_timing});
    chk("R8 clk_sel held during run", {24'h0, clk_sel}, {24'h0, prev_sel});
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    p = mdl_period(ct);
    cas_exp = mdl_cas(sup, ct2, ct3, p);
    chk("R3 clk_sel", {24'h0, clk_sel}, {24'h0, mdl_sel(ct)});
    chk(sup[4] ? "R4 cas field" : "R5 cas field", {30'h0, timing_byte[5:4]}, {30'h0, cas_exp});
    chk("R6 trp field", {30'h0, timing_byte[1:0]}, {30'h0, mdl_row(rp, p, 3)});
    chk("R6 trcd field", {30'h0, timing_byte[3:2]}, {30'h0, mdl_row(rcd, p, 3)});
    chk("R7 tras field", {30'h0, timing_byte[7:6]}, {30'h0, mdl_row(ras, p, 7)});
    chk("R2 fetch count", n_log, 7);
    for (int k = 0; k < 7; k++) chk("R2 fetch order", {24'h0, addr_log[k]}, {24'h0, order[k]});
    chk("R2 one request outstanding", {31'h0, hs_bad}, 0);
    prev_timing = timing_byte;
    prev_sel = clk_sel;
    @(negedge clk);
    chk("R8 done one cycle", {31'h0, done}, 0);
    repeat (6) @(negedge clk);
    chk("R8 timing holds after done", {24'h0, timing_byte}, {24'h0, prev_timing});
    chk("R8 done count", n_done - d0, 1);
    if (poke) begin
      chk("R9 busy start ignored, fetches", n_log, 7);
      chk("R9 busy start ignored, idle", {31'h0, req_valid}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 256; a++) spd[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 req_valid in reset", {31'h0, req_valid}, 0);
    chk("R1 done in reset", {31'h0, done}, 0);
    chk("R1 timing in reset", {24'h0, timing_byte}, 0);
    chk("R1 clk_sel in reset", {24'h0, clk_sel}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", {24'h0, timing_byte ^ clk_sel, 7'h0, req_valid | done}, 0);

    // R3 class boundaries
    run_case(8'h0C, 8'h50, 8'h60, 8'h70, 8'd60, 8'd60, 8'd140, 1'b0);
    run_case(8'h0C, 8'h51, 8'h60, 8'h70, 8'd60, 8'd60, 8'd140, 1'b0);
    run_case(8'h0C, 8'h60, 8'h60, 8'h70, 8'd72, 8'd72, 8'd168, 1'b0);
    run_case(8'h0C, 8'h61, 8'h60, 8'h70, 8'd90, 8'd90, 8'd210, 1'b0);
    // R4 downgrade paths (P = 0x14)
    run_case(8'h10, 8'h40, 8'h10, 8'h10, 8'd0, 8'd0, 8'd0, 1'b0);
    run_case(8'h18, 8'h40, 8'h14, 8'h15, 8'd0, 8'd0, 8'd0, 1'b0);
    run_case(8'h18, 8'h40, 8'h15, 8'h14, 8'd0, 8'd0, 8'd0, 1'b0);
    run_case(8'h1C, 8'h40, 8'h14, 8'h14, 8'd0, 8'd0, 8'd0, 1'b0);
    run_case(8'h14, 8'h40, 8'h30, 8'h14, 8'd0, 8'd0, 8'd0, 1'b0);
    // R5 paths
    run_case(8'h08, 8'h40, 8'h10, 8'h10, 8'd0, 8'd0, 8'd0, 1'b0);
    run_case(8'h0C, 8'h40, 8'h14, 8'h30, 8'd0, 8'd0, 8'd0, 1'b0);
    run_case(8'h0C, 8'h40, 8'h15, 8'h00, 8'd0, 8'd0, 8'd0, 1'b0);
    // R6 exact multiples and one below (P = 20)
    run_case(8'h0C, 8'h40, 8'h40, 8'h40, 8'd100, 8'd99, 8'd180, 1'b0);
    run_case(8'h0C, 8'h40, 8'h40, 8'h40, 8'd80, 8'd79, 8'd179, 1'b0);
    run_case(8'h0C, 8'h40, 8'h40, 8'h40, 8'd60, 8'd59, 8'd140, 1'b0);
    run_case(8'h0C, 8'h40, 8'h40, 8'h40, 8'd59, 8'd60, 8'd139, 1'b0);
    // R7 wide products at the slow period
    run_case(8'h0C, 8'h70, 8'h40, 8'h40, 8'hFF, 8'hFF, 8'hFF, 1'b0);
    run_case(8'h0C, 8'h70, 8'h40, 8'h40, 8'd150, 8'd120, 8'd239, 1'b0);
    // R9 start pulse during a run
    run_case(8'h1C, 8'h58, 8'h18, 8'h20, 8'd96, 8'd72, 8'd192, 1'b1);
    run_case(8'h10, 8'h64, 8'h20, 8'h20, 8'd120, 8'd90, 8'd220, 1'b1);

    for (int r = 0; r < 40; r++) begin
      logic [7:0] ct;
      case ($urandom % 4)
        0: ct = 8'h50 + 8'($urandom % 2);
        1: ct = 8'h60 + 8'($urandom % 2);
        default: ct = 8'($urandom);
      endcase
      run_case(8'($urandom) & 8'h1C, ct, 8'h10 + 8'($urandom % 24), 8'h10 + 8'($urandom % 24),
               8'($urandom), 8'($urandom), 8'($urandom), ($urandom % 5) == 0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule